// File: doc/BRIEF.md
# Fetch-Stage Branch Target Buffer

This block predicts control flow at fetch time. The fetch address, a virtual PC, is presented in the same cycle that the instruction cache is read. The buffer answers combinationally in that cycle with three outputs: whether a branch is known at that address, whether it is predicted taken, and where it goes. It also gives the address to fetch on the next cycle. The table is direct-mapped. Each slot keeps a valid bit, an address tag, an address-space identifier, a target and a two-bit saturating direction counter.

The execute stage trains the table through a resolution port. That port carries the branch PC, its address-space identifier, the actual direction and the actual target. A branch can only be predicted after it has resolved taken once. When a not-taken branch misses, nothing is written.

A build parameter selects how the table handles a process switch. In the tagged build, the identifier is part of the hit test and a process switch leaves the table alone. In the untagged build, the identifier is ignored and a process switch empties the whole table in a single cycle.

Top module: `fetch_btb`

## Requirements
- R1: After reset no slot is valid, so every lookup misses.
- R2: On a miss, `hit` and `pred_taken` are 0 and `next_pc` equals `fetch_pc + 4`.
- R3: A taken resolution that misses allocates a slot with counter value 2. From the next cycle on, a lookup of that PC (with the same identifier in the tagged build) returns `hit`=1, `pred_taken`=1, `pred_target` equal to the resolved target, and `next_pc` equal to that target.
- R4: A not-taken resolution that misses writes nothing, and later lookups of that PC still miss.
- R5: On every resolution that hits, the counter of that slot moves up by one if the branch was taken and down by one if it was not. It saturates at 0 and at 3. `pred_taken` is counter bit 1. A hit predicted not taken gives `hit`=1 and `next_pc` = `fetch_pc + 4`; a hit predicted taken gives `next_pc` = `pred_target`.
- R6: A taken resolution that hits overwrites the stored target. A not-taken resolution that hits keeps the stored target.
- R7: The slot index is PC bits [7:2] and the tag is PC bits [31:8]. A PC with the same index but a different tag misses. A taken resolution of that PC replaces the slot.
- R8: In the tagged build (`USE_ASID`=1), a hit also needs the stored identifier to equal `cur_asid`. `ctx_switch` has no effect on the table.
- R9: In the untagged build (`USE_ASID`=0), identifiers are ignored. `ctx_switch` invalidates every slot at the next edge, and it wins over a resolution in the same cycle.
- R10: When a lookup and a resolution touch the same slot in the same cycle, the lookup returns the contents from before the write. The write is visible from the next cycle.
- R11: The table changes only at an edge where `res_valid` or a clearing `ctx_switch` was high. With neither present, the outputs stay constant for constant lookup inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | 32 | Virtual fetch address of this cycle |
| cur_asid | input | 8 | Identifier of the running process |
| ctx_switch | input | 1 | Process switch pulse |
| res_valid | input | 1 | A resolved branch is presented |
| res_pc | input | 32 | PC of the resolved branch |
| res_asid | input | 8 | Identifier the branch ran under |
| res_taken | input | 1 | Actual direction, 1 = taken |
| res_target | input | 32 | Actual target address |
| hit | output | 1 | A known branch sits at `fetch_pc` |
| pred_taken | output | 1 | Predicted direction |
| pred_target | output | 32 | Stored target on a hit, 0 on a miss |
| next_pc | output | 32 | Address to fetch next cycle |

## Verification
A wrong counter shows up at the ports as a flipped `pred_taken` and a `next_pc` that falls through or redirects wrongly. That becomes visible on the first lookup after the resolution that moved the counter. For this reason the bench walks the counter through both saturation limits and looks up after every step. A lost or stray valid bit, or an identifier compared wrongly, shows up one cycle after the write or clear as a wrong `hit`. Running both builds side by side on the same stimulus separates the two process-switch policies. Same-slot collisions are sampled both before and after the edge so that a write that bypasses into the lookup is caught.

// File: rtl/btb_pkg.sv
package btb_pkg;
    localparam int BTB_PC_W   = 32;
    localparam int BTB_ASID_W = 8;
    localparam int BTB_IDX_W  = 6;

    localparam logic [1:0] CTR_FRESH = 2'd2;

    function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
        logic [1:0] nxt;
        if (taken) begin
            nxt = (cur == 2'd3) ? cur : cur + 2'd1;
        end else begin
            nxt = (cur == 2'd0) ? cur : cur - 2'd1;
        end
        return nxt;
    endfunction
endpackage

// File: rtl/btb_store.sv
module btb_store #(
    parameter int IDX_W  = 6,
    parameter int TAG_W  = 24,
    parameter int ASID_W = 8,
    parameter int PC_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_all,
    input  logic [IDX_W-1:0]  a_idx,
    output logic              a_valid,
    output logic [TAG_W-1:0]  a_tag,
    output logic [ASID_W-1:0] a_asid,
    output logic [PC_W-1:0]   a_target,
    output logic [1:0]        a_ctr,
    input  logic [IDX_W-1:0]  b_idx,
    output logic              b_valid,
    output logic [TAG_W-1:0]  b_tag,
    output logic [ASID_W-1:0] b_asid,
    output logic [PC_W-1:0]   b_target,
    output logic [1:0]        b_ctr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PC_W-1:0]   wr_target,
    input  logic [1:0]        wr_ctr
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q    [DEPTH];
    logic [ASID_W-1:0] asid_q   [DEPTH];
    logic [PC_W-1:0]   target_q [DEPTH];
    logic [1:0]        ctr_q    [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (clear_all) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]    <= wr_tag;
            asid_q[wr_idx]   <= wr_asid;
            target_q[wr_idx] <= wr_target;
            ctr_q[wr_idx]    <= wr_ctr;
        end
    end

    always_comb begin
        a_valid  = valid_q[a_idx];
        a_tag    = tag_q[a_idx];
        a_asid   = asid_q[a_idx];
        a_target = target_q[a_idx];
        a_ctr    = ctr_q[a_idx];
        b_valid  = valid_q[b_idx];
        b_tag    = tag_q[b_idx];
        b_asid   = asid_q[b_idx];
        b_target = target_q[b_idx];
        b_ctr    = ctr_q[b_idx];
    end
endmodule

// File: rtl/btb_probe.sv
module btb_probe #(
    parameter int TAG_W    = 24,
    parameter int ASID_W   = 8,
    parameter bit USE_ASID = 1'b1
) (
    input  logic [TAG_W-1:0]  want_tag,
    input  logic [ASID_W-1:0] want_asid,
    input  logic              ent_valid,
    input  logic [TAG_W-1:0]  ent_tag,
    input  logic [ASID_W-1:0] ent_asid,
    output logic              match
);
    logic asid_ok;

    generate
        if (USE_ASID) begin : g_tagged
            assign asid_ok = (ent_asid == want_asid);
        end else begin : g_untagged
            logic unused_asid;
            assign unused_asid = ^{ent_asid, want_asid};
            assign asid_ok     = 1'b1;
        end
    endgenerate

    assign match = ent_valid && (ent_tag == want_tag) && asid_ok;
endmodule

// File: rtl/btb_update.sv
module btb_update
    import btb_pkg::*;
#(
    parameter int TAG_W  = 24,
    parameter int ASID_W = 8,
    parameter int PC_W   = 32
) (
    input  logic              res_valid,
    input  logic              res_taken,
    input  logic [PC_W-1:0]   res_target,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic [ASID_W-1:0] res_asid,
    input  logic              block,
    input  logic              slot_match,
    input  logic [PC_W-1:0]   slot_target,
    input  logic [1:0]        slot_ctr,
    output logic              wr_en,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [ASID_W-1:0] wr_asid,
    output logic [PC_W-1:0]   wr_target,
    output logic [1:0]        wr_ctr
);
    always_comb begin
        wr_en     = 1'b0;
        wr_tag    = res_tag;
        wr_asid   = res_asid;
        wr_target = res_target;
        wr_ctr    = CTR_FRESH;
        if (res_valid && !block) begin
            if (slot_match) begin
                wr_en     = 1'b1;
                wr_ctr    = ctr_step(slot_ctr, res_taken);
                wr_target = res_taken ? res_target : slot_target;
            end else if (res_taken) begin
                wr_en = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fetch_btb.sv
module fetch_btb
    import btb_pkg::*;
#(
    parameter int PC_W     = BTB_PC_W,
    parameter int ASID_W   = BTB_ASID_W,
    parameter int IDX_W    = BTB_IDX_W,
    parameter bit USE_ASID = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   fetch_pc,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic              ctx_switch,
    input  logic              res_valid,
    input  logic [PC_W-1:0]   res_pc,
    input  logic [ASID_W-1:0] res_asid,
    input  logic              res_taken,
    input  logic [PC_W-1:0]   res_target,
    output logic              hit,
    output logic              pred_taken,
    output logic [PC_W-1:0]   pred_target,
    output logic [PC_W-1:0]   next_pc
);
    localparam int TAG_W = PC_W - IDX_W - 2;
    localparam logic [PC_W-1:0] STEP = PC_W'(4);

    logic [IDX_W-1:0]  f_idx, r_idx, wr_idx;
    logic [TAG_W-1:0]  f_tag, r_tag;
    logic              fa_valid, rb_valid;
    logic [TAG_W-1:0]  fa_tag, rb_tag, wr_tag;
    logic [ASID_W-1:0] fa_asid, rb_asid, wr_asid;
    logic [PC_W-1:0]   fa_target, rb_target, wr_target;
    logic [1:0]        fa_ctr, rb_ctr, wr_ctr;
    logic              f_match, res_hit, wr_en, clear_all;
    logic              unused_lo;

    assign f_idx     = fetch_pc[IDX_W+1:2];
    assign f_tag     = fetch_pc[PC_W-1:IDX_W+2];
    assign r_idx     = res_pc[IDX_W+1:2];
    assign r_tag     = res_pc[PC_W-1:IDX_W+2];
    assign wr_idx    = r_idx;
    assign unused_lo = ^{fetch_pc[1:0], res_pc[1:0]};
    assign clear_all = ctx_switch && (USE_ASID == 1'b0);

    btb_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .ASID_W(ASID_W), .PC_W(PC_W)) u_store (
        .clk(clk), .rst_n(rst_n), .clear_all(clear_all),
        .a_idx(f_idx), .a_valid(fa_valid), .a_tag(fa_tag), .a_asid(fa_asid),
        .a_target(fa_target), .a_ctr(fa_ctr),
        .b_idx(r_idx), .b_valid(rb_valid), .b_tag(rb_tag), .b_asid(rb_asid),
        .b_target(rb_target), .b_ctr(rb_ctr),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_asid(wr_asid),
        .wr_target(wr_target), .wr_ctr(wr_ctr)
    );

    btb_probe #(.TAG_W(TAG_W), .ASID_W(ASID_W), .USE_ASID(USE_ASID)) u_fetch_probe (
        .want_tag(f_tag), .want_asid(cur_asid),
        .ent_valid(fa_valid), .ent_tag(fa_tag), .ent_asid(fa_asid),
        .match(f_match)
    );

    btb_probe #(.TAG_W(TAG_W), .ASID_W(ASID_W), .USE_ASID(USE_ASID)) u_res_probe (
        .want_tag(r_tag), .want_asid(res_asid),
        .ent_valid(rb_valid), .ent_tag(rb_tag), .ent_asid(rb_asid),
        .match(res_hit)
    );

    btb_update #(.TAG_W(TAG_W), .ASID_W(ASID_W), .PC_W(PC_W)) u_update (
        .res_valid(res_valid), .res_taken(res_taken), .res_target(res_target),
        .res_tag(r_tag), .res_asid(res_asid), .block(clear_all),
        .slot_match(res_hit), .slot_target(rb_target), .slot_ctr(rb_ctr),
        .wr_en(wr_en), .wr_tag(wr_tag), .wr_asid(wr_asid),
        .wr_target(wr_target), .wr_ctr(wr_ctr)
    );

    always_comb begin
        hit         = f_match;
        pred_taken  = f_match && fa_ctr[1];
        pred_target = f_match ? fa_target : '0;
        next_pc     = pred_taken ? fa_target : fetch_pc + STEP;
    end
endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
    parameter int PC_W     = 32,
    parameter int ASID_W   = 8,
    parameter bit USE_ASID = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PC_W-1:0]   fetch_pc,
    input logic [ASID_W-1:0] cur_asid,
    input logic              ctx_switch,
    input logic              res_valid,
    input logic [PC_W-1:0]   res_pc,
    input logic [ASID_W-1:0] res_asid,
    input logic              res_taken,
    input logic [PC_W-1:0]   res_target,
    input logic              res_hit,
    input logic              hit,
    input logic              pred_taken,
    input logic [PC_W-1:0]   pred_target,
    input logic [PC_W-1:0]   next_pc
);
    localparam logic [PC_W-1:0] STEP = PC_W'(4);
    logic blocking;
    assign blocking = ctx_switch && (USE_ASID == 1'b0);

    AST_MISS_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (!pred_taken && next_pc == fetch_pc + STEP)); // R2

    AST_TAKEN_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && pred_taken) |-> (next_pc == pred_target)); // R5

    AST_ALLOC_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_taken && !res_hit && !blocking) ##1
        (fetch_pc == $past(res_pc) && cur_asid == $past(res_asid))
        |-> (hit && pred_taken && pred_target == $past(res_target))); // R3

    AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_valid && !blocking) ##1 ($stable(fetch_pc) && $stable(cur_asid))
        |-> ($stable(hit) && $stable(pred_taken) && $stable(pred_target))); // R11

    generate
        if (!USE_ASID) begin : g_clear_chk
            AST_SWITCH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
                ctx_switch |=> !hit); // R9
        end
    endgenerate
endmodule

bind fetch_btb btb_checker #(.PC_W(PC_W), .ASID_W(ASID_W), .USE_ASID(USE_ASID)) u_btb_checker (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .cur_asid(cur_asid),
    .ctx_switch(ctx_switch), .res_valid(res_valid), .res_pc(res_pc),
    .res_asid(res_asid), .res_taken(res_taken), .res_target(res_target),
    .res_hit(res_hit), .hit(hit), .pred_taken(pred_taken),
    .pred_target(pred_target), .next_pc(next_pc)
);

// File: tb/test_fetch_btb.sv
`timescale 1ns/1ps
module test_fetch_btb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic [7:0]  cur_asid = '0;
    logic        ctx_switch = 1'b0;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = '0;
    logic [7:0]  res_asid = '0;
    logic        res_taken = 1'b0;
    logic [31:0] res_target = '0;

    logic        a_hit, a_tk, n_hit, n_tk;
    logic [31:0] a_tgt, a_nxt, n_tgt, n_nxt;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    fetch_btb #(.USE_ASID(1'b1)) i_fetch_btb (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .cur_asid(cur_asid),
        .ctx_switch(ctx_switch), .res_valid(res_valid), .res_pc(res_pc),
        .res_asid(res_asid), .res_taken(res_taken), .res_target(res_target),
        .hit(a_hit), .pred_taken(a_tk), .pred_target(a_tgt), .next_pc(a_nxt)
    );

    fetch_btb #(.USE_ASID(1'b0)) i_fetch_btb_noasid (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .cur_asid(cur_asid),
        .ctx_switch(ctx_switch), .res_valid(res_valid), .res_pc(res_pc),
        .res_asid(res_asid), .res_taken(res_taken), .res_target(res_target),
        .hit(n_hit), .pred_taken(n_tk), .pred_target(n_tgt), .next_pc(n_nxt)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic look(input logic [31:0] pc, input logic [7:0] asid);
        @(negedge clk);
        fetch_pc = pc;
        cur_asid = asid;
        #1;
    endtask

    task automatic resolve(input logic [31:0] pc, input logic [7:0] asid,
                           input logic tk, input logic [31:0] tgt);
        @(negedge clk);
        res_valid = 1'b1; res_pc = pc; res_asid = asid;
        res_taken = tk; res_target = tgt;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic expect_a(input string req, input logic h, input logic t,
                            input logic [31:0] nxt);
        check({req, " hit"}, {31'd0, a_hit}, {31'd0, h});
        check({req, " taken"}, {31'd0, a_tk}, {31'd0, t});
        check({req, " next_pc"}, a_nxt, nxt);
    endtask

    task automatic t_reset();
        look(32'h0000_1000, 8'd1);
        expect_a("R1", 1'b0, 1'b0, 32'h0000_1004);
        check("R1 untagged hit", {31'd0, n_hit}, 32'd0);
    endtask

    task automatic t_miss();
        look(32'h0000_2340, 8'd3);
        expect_a("R2", 1'b0, 1'b0, 32'h0000_2344);
        check("R2 target", a_tgt, 32'd0);
    endtask

    task automatic t_alloc();
        resolve(32'h0000_0100, 8'd1, 1'b1, 32'h0000_0800);
        look(32'h0000_0100, 8'd1);
        expect_a("R3", 1'b1, 1'b1, 32'h0000_0800);
        check("R3 target", a_tgt, 32'h0000_0800);
    endtask

    task automatic t_nt_noalloc();
        resolve(32'h0000_0204, 8'd1, 1'b0, 32'h0000_0900);
        look(32'h0000_0204, 8'd1);
        expect_a("R4", 1'b0, 1'b0, 32'h0000_0208);
    endtask

    task automatic t_counter();
        // slot for 0x100 holds counter 2
        resolve(32'h100, 8'd1, 1'b0, 32'h0);
        look(32'h100, 8'd1);
        expect_a("R5 ctr1", 1'b1, 1'b0, 32'h104);
        resolve(32'h100, 8'd1, 1'b0, 32'h0);
        resolve(32'h100, 8'd1, 1'b0, 32'h0);
        resolve(32'h100, 8'd1, 1'b1, 32'h800);
        look(32'h100, 8'd1);
        expect_a("R5 floor", 1'b1, 1'b0, 32'h104);
        resolve(32'h100, 8'd1, 1'b1, 32'h800);
        look(32'h100, 8'd1);
        expect_a("R5 ctr2", 1'b1, 1'b1, 32'h800);
        for (int k = 0; k < 3; k++) resolve(32'h100, 8'd1, 1'b1, 32'h800);
        resolve(32'h100, 8'd1, 1'b0, 32'h0);
        look(32'h100, 8'd1);
        expect_a("R5 ceiling", 1'b1, 1'b1, 32'h800);
        resolve(32'h100, 8'd1, 1'b0, 32'h0);
        look(32'h100, 8'd1);
        expect_a("R5 down", 1'b1, 1'b0, 32'h104);
        resolve(32'h100, 8'd1, 1'b1, 32'h800);
    endtask

    task automatic t_target();
        resolve(32'h100, 8'd1, 1'b1, 32'h0000_0A00);
        look(32'h100, 8'd1);
        check("R6 new target", a_tgt, 32'h0000_0A00);
        resolve(32'h100, 8'd1, 1'b0, 32'h0000_0B00);
        look(32'h100, 8'd1);
        check("R6 kept target", a_tgt, 32'h0000_0A00);
        expect_a("R6", 1'b1, 1'b1, 32'h0000_0A00);
    endtask

    task automatic t_alias();
        look(32'h0000_1100, 8'd1);
        expect_a("R7 alias miss", 1'b0, 1'b0, 32'h0000_1104);
        resolve(32'h0000_1100, 8'd1, 1'b1, 32'h0000_0C00);
        resolve(32'h0000_0104, 8'd1, 1'b1, 32'h0000_0400);
        look(32'h0000_1100, 8'd1);
        expect_a("R7 replaced", 1'b1, 1'b1, 32'h0000_0C00);
        look(32'h0000_0100, 8'd1);
        expect_a("R7 evicted", 1'b0, 1'b0, 32'h0000_0104);
        look(32'h0000_0104, 8'd1);
        expect_a("R7 neighbour", 1'b1, 1'b1, 32'h0000_0400);
    endtask

    task automatic t_asid();
        resolve(32'h0000_0300, 8'd1, 1'b1, 32'h0000_3000);
        look(32'h0000_0300, 8'd2);
        expect_a("R8 other asid", 1'b0, 1'b0, 32'h0000_0304);
        check("R9 asid ignored", {31'd0, n_hit}, 32'd1);
        @(negedge clk); ctx_switch = 1'b1;
        @(negedge clk); ctx_switch = 1'b0;
        look(32'h0000_0300, 8'd1);
        expect_a("R8 survives switch", 1'b1, 1'b1, 32'h0000_3000);
        check("R9 cleared", {31'd0, n_hit}, 32'd0);
        look(32'h0000_1100, 8'd1);
        check("R9 cleared other", {31'd0, n_hit}, 32'd0);
        check("R9 next_pc", n_nxt, 32'h0000_1104);
        @(negedge clk);
        ctx_switch = 1'b1;
        res_valid = 1'b1; res_pc = 32'h500; res_asid = 8'd1;
        res_taken = 1'b1; res_target = 32'h5000;
        @(negedge clk);
        ctx_switch = 1'b0; res_valid = 1'b0;
        look(32'h500, 8'd1);
        check("R9 clear wins", {31'd0, n_hit}, 32'd0);
        expect_a("R8 alloc during switch", 1'b1, 1'b1, 32'h5000);
    endtask

    task automatic t_same_cycle();
        resolve(32'h600, 8'd1, 1'b1, 32'h6000);
        @(negedge clk);
        fetch_pc = 32'h600; cur_asid = 8'd1;
        res_valid = 1'b1; res_pc = 32'h600; res_asid = 8'd1;
        res_taken = 1'b1; res_target = 32'h7000;
        #1;
        check("R10 old target", a_tgt, 32'h6000);
        @(negedge clk);
        res_valid = 1'b0;
        #1;
        check("R10 new target", a_tgt, 32'h7000);
        @(negedge clk);
        fetch_pc = 32'h700;
        res_valid = 1'b1; res_pc = 32'h700; res_taken = 1'b1; res_target = 32'h7700;
        #1;
        expect_a("R10 alloc not yet", 1'b0, 1'b0, 32'h704);
        @(negedge clk);
        res_valid = 1'b0;
        #1;
        expect_a("R10 alloc visible", 1'b1, 1'b1, 32'h7700);
    endtask

    task automatic t_quiet();
        look(32'h700, 8'd1);
        repeat (4) @(negedge clk);
        #1;
        expect_a("R11 idle", 1'b1, 1'b1, 32'h7700);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_miss();
        t_alloc();
        t_nt_noalloc();
        t_counter();
        t_target();
        t_alias();
        t_asid();
        t_same_cycle();
        t_quiet();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule